// File: doc/BRIEF.md
# Sector Write Buffer Controller

This block is the write path of a byte-wide paged nonvolatile memory. A host drives a chip select, a write strobe, an output gate, an 18-bit address and an 8-bit data bus. The block samples these with the system clock. Each byte load is placed in a 256-entry sector buffer. The first accepted byte of a load window fixes the sector. Later bytes may arrive in any order, but they must target that same sector.

When no new load begins within a programmable number of timebase ticks, the window closes. `busy` then rises for a fixed number of ticks, which models the internal erase-plus-program cycle. At the end of that cycle the whole sector is rewritten at once. Loaded bytes take their buffered values, and every byte of the sector that was not loaded takes the erased fill value.

A read returns the stored byte while the chip is selected, the output gate is active and the write strobe is idle. The behavioural array stores 2^`SLOT_W` sectors, and sectors alias onto these by their low sector bits.

Top module: `sector_wbuf_ctrl`

## Requirements
- R1: After reset, `busy` and `sect_err` are 0 and every location reads the fill value FILL (default 8'hFF).
- R2: A byte load captures the address in the first clock cycle in which `ce_n`, `we_n` are both low with `oe_n` high. It captures the data last seen before either `ce_n` or `we_n` returns high. Address bits 17:8 are the sector and bits 7:0 the byte offset.
- R3: A strobe during which `oe_n` is low loads nothing and does not open a load window.
- R4: `busy` rises exactly TIMEOUT_TICKS tick cycles after the end of the last accepted load. A new load starting before that restarts the count, and the timeout count is held while a strobe is active.
- R5: Cycles with `tick` low do not advance the timeout or the program timer.
- R6: `busy` stays high for exactly PROG_TICKS tick cycles. When it falls, every loaded byte reads back its loaded value.
- R7: Every byte of the programmed sector that was not loaded in the window reads FILL afterwards, even if it held data before.
- R8: Bytes may be loaded in any order. A repeated offset keeps the last value loaded.
- R9: A load whose sector differs from the first byte of the window is dropped and sets `sect_err`. `sect_err` stays 1 until reset.
- R10: A load that starts or ends while `busy` is high is dropped and opens no new window.
- R11: `rd_data` shows the array only when `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 otherwise. Sector s and sector s+2^SLOT_W share storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one count per high cycle |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | 18 | Sector (17:8) and byte offset (7:0) |
| din | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not reading |
| busy | output | 1 | Program cycle in progress |
| sect_err | output | 1 | Sticky flag for a dropped wrong-sector load |

## Verification
A load ends on the first clock edge after the strobe is released, so `sect_err` is checked at the falling clock edge right after that edge. `busy` is checked one edge before and exactly at edge TIMEOUT_TICKS after it, counting only cycles with `tick` high. The high time of `busy` is measured by counting falling edges, and must equal PROG_TICKS. Reads are combinational: the bench drives a read at a falling edge, samples 1 ns later, and only reads after `busy` has dropped, so the commit edge has already passed.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int ADDR_W = 18;
  localparam int OFF_W  = 8;
  localparam int DATA_W = 8;
  localparam int SECT_W = ADDR_W - OFF_W;
  localparam int OFF_N  = 1 << OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } swb_state_e;

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
endpackage

// File: rtl/swb_strobe.sv
module swb_strobe
  import swb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output logic              load_evt,
  output logic              strobe_act,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);
  logic act_now, act_q, start_evt, end_evt, busy_at_start;

  always_comb begin
    act_now    = !ce_n && !we_n && oe_n;
    start_evt  = act_now && !act_q;
    // release by ce_n or we_n with the output gate still high
    end_evt    = act_q && (ce_n || we_n) && oe_n;
    load_evt   = end_evt && !busy_at_start && !busy;
    strobe_act = act_now || act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q         <= 1'b0;
      ld_addr       <= '0;
      ld_data       <= '0;
      busy_at_start <= 1'b0;
    end else begin
      act_q <= act_now;
      if (start_evt) begin
        ld_addr       <= addr;
        busy_at_start <= busy;
      end
      if (act_now) ld_data <= din;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && act_now) |=> $stable(ld_addr)); // R2
endmodule

// File: rtl/swb_window.sv
module swb_window
  import swb_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 150,
  parameter int PROG_TICKS    = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_evt,
  input  logic              strobe_act,
  input  logic [SECT_W-1:0] ld_sector,
  output logic              accept,
  output logic              commit,
  output logic              busy,
  output logic              err,
  output logic [SECT_W-1:0] lock
);
  localparam int CNT_MAX = (TIMEOUT_TICKS > PROG_TICKS) ? TIMEOUT_TICKS : PROG_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  swb_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             mismatch, timeout_hit;

  always_comb begin
    accept      = load_evt && ((state == ST_IDLE) ||
                               (state == ST_LOAD && ld_sector == lock));
    mismatch    = load_evt && state == ST_LOAD && ld_sector != lock;
    timeout_hit = state == ST_LOAD && tick && !strobe_act &&
                  cnt == CNT_W'(TIMEOUT_TICKS - 1);
    commit      = state == ST_PROG && tick && cnt == CNT_W'(PROG_TICKS - 1);
    busy        = state == ST_PROG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lock  <= '0;
      err   <= 1'b0;
    end else begin
      if (mismatch) err <= 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOAD;
          lock  <= ld_sector;
          cnt   <= '0;
        end
        ST_LOAD: begin
          if (accept) cnt <= '0;
          else if (timeout_hit) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else if (tick && !strobe_act) cnt <= cnt + CNT_W'(1);
        end
        ST_PROG: begin
          if (commit) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CNT_MAX)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(lock)); // R9
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && !tick) |=> $stable(cnt)); // R5
endmodule

// File: rtl/swb_buffer.sv
module swb_buffer
  import swb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    commit,
  input  logic [OFF_W-1:0]        ld_off,
  input  logic [DATA_W-1:0]       ld_data,
  output logic [OFF_N*DATA_W-1:0] buf_data,
  output logic [OFF_N-1:0]        buf_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data  <= '0;
      buf_valid <= '0;
    end else if (commit) begin
      buf_valid <= '0;
    end else if (accept) begin
      buf_valid[ld_off]                  <= 1'b1;
      buf_data[ld_off*DATA_W +: DATA_W]  <= ld_data;
    end
  end

  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (buf_valid == '0)); // R6
  AST_ONE_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($countones(buf_valid) <= $countones($past(buf_valid)) + 1)); // R8
endmodule

// File: rtl/swb_array.sv
module swb_array
  import swb_pkg::*;
#(
  parameter int              SLOT_W = 2,
  parameter logic [DATA_W-1:0] FILL = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [SLOT_W-1:0]       commit_slot,
  input  logic [OFF_N*DATA_W-1:0] buf_data,
  input  logic [OFF_N-1:0]        buf_valid,
  input  logic [SLOT_W-1:0]       rd_slot,
  input  logic [OFF_W-1:0]        rd_off,
  output logic [DATA_W-1:0]       rd_q
);
  localparam int DEPTH = (1 << SLOT_W) * OFF_N;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
    end else if (commit) begin
      for (int i = 0; i < OFF_N; i++)
        mem[{commit_slot, OFF_W'(i)}] <= buf_valid[i] ? buf_data[i*DATA_W +: DATA_W] : FILL;
    end
  end

  assign rd_q = mem[{rd_slot, rd_off}];
endmodule

// File: rtl/sector_wbuf_ctrl.sv
module sector_wbuf_ctrl
  import swb_pkg::*;
#(
  parameter int                TIMEOUT_TICKS = 150,
  parameter int                PROG_TICKS    = 10000,
  parameter int                SLOT_W        = 2,
  parameter logic [DATA_W-1:0] FILL          = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              sect_err
);
  logic                    load_evt, strobe_act, accept, commit;
  logic [ADDR_W-1:0]       ld_addr;
  logic [DATA_W-1:0]       ld_data, arr_q;
  logic [SECT_W-1:0]       lock;
  logic [OFF_N*DATA_W-1:0] buf_data;
  logic [OFF_N-1:0]        buf_valid;
  logic                    rd_en;

  swb_strobe u_strobe (
    .clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .din, .busy,
    .load_evt, .strobe_act, .ld_addr, .ld_data
  );

  swb_window #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .PROG_TICKS(PROG_TICKS)) u_window (
    .clk, .rst_n, .tick, .load_evt, .strobe_act,
    .ld_sector(sector_of(ld_addr)),
    .accept, .commit, .busy, .err(sect_err), .lock
  );

  swb_buffer u_buffer (
    .clk, .rst_n, .accept, .commit,
    .ld_off(offset_of(ld_addr)), .ld_data,
    .buf_data, .buf_valid
  );

  swb_array #(.SLOT_W(SLOT_W), .FILL(FILL)) u_array (
    .clk, .rst_n, .commit,
    .commit_slot(lock[SLOT_W-1:0]),
    .buf_data, .buf_valid,
    .rd_slot(addr[OFF_W+SLOT_W-1:OFF_W]),
    .rd_off(offset_of(addr)),
    .rd_q(arr_q)
  );

  always_comb begin
    rd_en   = !ce_n && !oe_n && we_n;
    rd_data = rd_en ? arr_q : '0;
  end

  AST_PROG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (buf_valid != '0)); // R4
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(buf_valid)); // R10
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !commit) |=> $stable(buf_valid)); // R3
  AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (rd_data == '0)); // R11
endmodule

// File: tb/sector_wbuf_ctrl_tb_top.sv
module sector_wbuf_ctrl_tb_top;
  localparam int TO = 8;
  localparam int PG = 20;
  localparam logic [25:0] LOAD_TAB [0:5] = '{
    {18'h00580, 8'hA1}, {18'h00503, 8'h3B}, {18'h005FF, 8'hC4},
    {18'h00500, 8'h00}, {18'h00541, 8'h7E}, {18'h00503, 8'h96}
  };

  logic clk = 0, rst_n = 0, tick = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  rd_data;
  logic        busy, sect_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sector_wbuf_ctrl #(.TIMEOUT_TICKS(TO), .PROG_TICKS(PG), .SLOT_W(2), .FILL(8'hFF)) dut_i (
    .clk, .rst_n, .tick, .ce_n, .we_n, .oe_n, .addr, .din, .rd_data, .busy, .sect_err
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [17:0] a, input logic [7:0] d, input logic oe = 1'b1);
    @(negedge clk);
    addr = a; din = d; oe_n = oe; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    #1 q = rd_data;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_done();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] off);
    logic [7:0] r = 8'hFF;
    for (int i = 0; i < 6; i++) if (LOAD_TAB[i][15:8] == off) r = LOAD_TAB[i][7:0];
    return r;
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 err", sect_err, 0);
    rd(18'h00580, q); chk("R1 fill", q, 8'hFF);

    // table walk: sector 5, scrambled order with a repeated offset (R8)
    for (int i = 0; i < 6; i++) load(LOAD_TAB[i][25:8], LOAD_TAB[i][7:0]);
    repeat (TO) @(negedge clk);
    chk("R4 busy before timeout", busy, 0);
    @(negedge clk);
    chk("R4 busy at timeout", busy, 1);
    hi = 1;
    while (busy) begin @(negedge clk); if (busy) hi++; end
    chk("R6 busy length", hi, PG);
    for (int i = 0; i < 6; i++) begin
      rd(LOAD_TAB[i][25:8], q);
      chk("R8 readback", q, exp_byte(LOAD_TAB[i][15:8]));
    end
    rd(18'h00501, q); chk("R7 unloaded 01", q, 8'hFF);
    rd(18'h0057F, q); chk("R7 unloaded 7F", q, 8'hFF);
    rd(18'h00980, q); chk("R11 alias", q, 8'hA1);

    // reprogram with one byte: old bytes become fill (R7)
    load(18'h00510, 8'h3C);
    wait_done();
    rd(18'h00510, q); chk("R6 new byte", q, 8'h3C);
    rd(18'h00580, q); chk("R7 old byte erased", q, 8'hFF);

    // address at strobe start, data at strobe end (R2)
    @(negedge clk);
    addr = 18'h00207; din = 8'h11; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk);
    addr = 18'h00208; din = 8'h5A;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    wait_done();
    rd(18'h00207, q); chk("R2 data at release", q, 8'h5A);
    rd(18'h00208, q); chk("R2 late address unused", q, 8'hFF);

    // restart of timeout (R4) and tick gating (R5)
    load(18'h00301, 8'hA5);
    repeat (TO - 2) @(negedge clk);
    chk("R4 restart pre", busy, 0);
    load(18'h00302, 8'h5A);
    tick = 0;
    repeat (3 * TO) @(negedge clk);
    chk("R5 no tick no timeout", busy, 0);
    tick = 1;
    repeat (TO - 1) @(negedge clk);
    chk("R5 count resumes", busy, 0);
    @(negedge clk);
    chk("R4 restarted timeout", busy, 1);
    // load while busy (R10)
    load(18'h00320, 8'h77);
    wait_done();
    rd(18'h00301, q); chk("R4 first byte", q, 8'hA5);
    rd(18'h00302, q); chk("R4 second byte", q, 8'h5A);
    rd(18'h00320, q); chk("R10 busy load dropped", q, 8'hFF);
    repeat (TO + 3) @(negedge clk);
    chk("R10 no new window", busy, 0);

    // output gate low blocks load (R3)
    load(18'h00005, 8'h99, 1'b0);
    repeat (TO + 3) @(negedge clk);
    chk("R3 no window", busy, 0);
    rd(18'h00005, q); chk("R3 no data", q, 8'hFF);
    chk("R9 err clear", sect_err, 0);

    // wrong sector (R9)
    load(18'h10001, 8'h11);
    load(18'h10102, 8'h22);
    @(negedge clk);
    chk("R9 err set", sect_err, 1);
    wait_done();
    rd(18'h10001, q); chk("R9 good byte", q, 8'h11);
    rd(18'h10102, q); chk("R9 bad byte dropped", q, 8'hFF);
    chk("R9 err sticky", sect_err, 1);

    // read gating (R11)
    @(negedge clk);
    addr = 18'h10001; ce_n = 0; oe_n = 1; we_n = 1;
    #1 chk("R11 gate off", rd_data, 8'h00);
    ce_n = 1;

    // reset again (R1)
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 err after reset", sect_err, 0);
    chk("R1 busy after reset", busy, 0);
    rd(18'h10001, q); chk("R1 array refilled", q, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule